// File: doc/BRIEF.md
# Function-Coded Integer ALU

This block is a purely combinational integer arithmetic/logic unit. It takes two operands of `WIDTH` bits (32 by default) and a 3-bit function code, and returns a `WIDTH`-bit result and a flag that is high when the result is all zeros. It holds no state and uses no clock. Results are valid as soon as the inputs settle.

Every arithmetic code runs through one shared prefix adder. The top bit of the function code selects the conditioned B operand. When that bit is set, B is inverted and the same bit enters the adder as carry-in, so the adder computes A minus B. The low two bits of the code choose the result source: bitwise AND, bitwise OR, the adder sum, or the sign of the sum. The sign is placed in bit 0 and every other result bit is zero. Set-less-than reads that sign bit straight from the difference. It does not correct for signed overflow.

Top module: `alu_core`

## Requirements
- R1: Code 3'b000 gives Y = A & B.
- R2: Code 3'b001 gives Y = A | B.
- R3: Code 3'b010 gives Y = (A + B) mod 2^WIDTH. The carry out of the top bit is dropped, so 0xFFFFFFFF + 1 gives 0.
- R4: Code 3'b100 gives Y = A & ~B, and code 3'b101 gives Y = A | ~B.
- R5: Code 3'b110 gives Y = (A - B) mod 2^WIDTH, formed as A + ~B + 1.
- R6: Code 3'b111 gives Y with bit 0 equal to bit WIDTH-1 of (A - B) mod 2^WIDTH and every other bit 0. For example, A=25 and B=32 give 0x00000001, and A=0x80000000 and B=1 give 0 because the difference wraps.
- R7: Code 3'b011 gives Y = 0 for every operand.
- R8: The zero flag is 1 exactly when every bit of Y is 0.
- R9: With WIDTH=4, R1 to R8 hold for every operand pair and every code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| func_i | input | 3 | Function code. Bit 2 inverts B and sets carry-in. Bits 1:0 select the result source |
| y_o | output | WIDTH | Result |
| zero_o | output | 1 | High when y_o is all zeros |

## Verification
The hardest cases to reach from the ports are a carry that ripples across every column of the prefix network, and a set-less-than whose difference wraps past the signed range, where the reported sign disagrees with the true signed order. A 4-bit copy of the block is swept over every operand pair and every code, which drives each prefix span and wrap pattern. The 32-bit instance is then driven with a cross product of edge operands: zero, one, all ones, the most positive and most negative values, and equal pairs. This set includes 0xFFFFFFFF + 1 and 0x80000000 compared with 1.

// File: rtl/alu_pkg.sv
package alu_pkg;

  // Position of the code bit that inverts B and supplies the carry-in.
  localparam int unsigned INV_BIT = 2;

  // Result source picked by the low two code bits.
  typedef enum logic [1:0] {
    SEL_AND  = 2'b00,
    SEL_OR   = 2'b01,
    SEL_SUM  = 2'b10,
    SEL_SIGN = 2'b11
  } res_sel_e;

endpackage

// File: rtl/alu_operand_cond.sv
module alu_operand_cond #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] b_i,
  input  logic             inv_i,
  output logic [WIDTH-1:0] b_eff_o,
  output logic             cin_o
);

  // One XOR per bit: inversion is applied as a conditional complement.
  assign b_eff_o = b_i ^ {WIDTH{inv_i}};
  // The same control bit adds the +1 that completes two's-complement negation.
  assign cin_o   = inv_i;

endmodule

// File: rtl/alu_prefix_adder.sv
module alu_prefix_adder #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o
);

  // Only columns 0..WIDTH-2 feed a carry into a higher column; the carry
  // out of the top column is never needed, so the network spans PW columns.
  localparam int unsigned PW     = WIDTH - 1;
  localparam int unsigned LEVELS = (PW > 1) ? $clog2(PW) : 1;

  logic [WIDTH-1:0] half_sum;
  logic [WIDTH-1:0] carry_in;

  assign half_sum = a_i ^ b_i;

  // Parallel-prefix (log-depth) generate/propagate tree.
  for (genvar k = 0; k <= LEVELS; k++) begin : g_lvl
    logic [PW-1:0] gg;
    logic [PW-1:0] pp;
    if (k == 0) begin : g_init
      assign gg = a_i[PW-1:0] & b_i[PW-1:0];
      assign pp = a_i[PW-1:0] ^ b_i[PW-1:0];
    end else begin : g_step
      localparam int unsigned D = 1 << (k - 1);
      for (genvar i = 0; i < PW; i++) begin : g_col
        if (i >= D) begin : g_blk
          assign gg[i] = g_lvl[k-1].gg[i] | (g_lvl[k-1].pp[i] & g_lvl[k-1].gg[i-D]);
          assign pp[i] = g_lvl[k-1].pp[i] & g_lvl[k-1].pp[i-D];
        end else begin : g_pass
          assign gg[i] = g_lvl[k-1].gg[i];
          assign pp[i] = g_lvl[k-1].pp[i];
        end
      end
    end
  end

  // Carry into column i: the group generate over columns i-1..0, or the
  // group propagate over them letting the external carry-in through.
  assign carry_in[0] = cin_i;
  for (genvar i = 1; i < WIDTH; i++) begin : g_carry
    assign carry_in[i] = g_lvl[LEVELS].gg[i-1] | (g_lvl[LEVELS].pp[i-1] & cin_i);
  end

  assign sum_o = half_sum ^ carry_in;

endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_eff_i,
  output logic [WIDTH-1:0] and_o,
  output logic [WIDTH-1:0] or_o
);

  assign and_o = a_i & b_eff_i;
  assign or_o  = a_i | b_eff_i;

endmodule

// File: rtl/alu_result_mux.sv
module alu_result_mux
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [2:0]       func_i,
  input  logic [WIDTH-1:0] and_i,
  input  logic [WIDTH-1:0] or_i,
  input  logic [WIDTH-1:0] sum_i,
  output logic [WIDTH-1:0] y_o
);

  res_sel_e sel;
  assign sel = res_sel_e'(func_i[1:0]);

  always_comb begin
    unique case (sel)
      SEL_AND: y_o = and_i;
      SEL_OR:  y_o = or_i;
      SEL_SUM: y_o = sum_i;
      SEL_SIGN: begin
        // Sign of the difference only when B was inverted; otherwise the
        // code is unused and the result is forced to zero.
        y_o    = '0;
        y_o[0] = func_i[INV_BIT] & sum_i[WIDTH-1];
      end
      default: y_o = '0;
    endcase
  end

endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [2:0]       func_i,
  output logic [WIDTH-1:0] y_o,
  output logic             zero_o
);

  logic [WIDTH-1:0] b_eff;
  logic             cin;
  logic [WIDTH-1:0] sum;
  logic [WIDTH-1:0] and_r;
  logic [WIDTH-1:0] or_r;

  alu_operand_cond #(.WIDTH(WIDTH)) u_cond (
    .b_i     (b_i),
    .inv_i   (func_i[INV_BIT]),
    .b_eff_o (b_eff),
    .cin_o   (cin)
  );

  alu_prefix_adder #(.WIDTH(WIDTH)) u_add (
    .a_i   (a_i),
    .b_i   (b_eff),
    .cin_i (cin),
    .sum_o (sum)
  );

  alu_logic_unit #(.WIDTH(WIDTH)) u_logic (
    .a_i     (a_i),
    .b_eff_i (b_eff),
    .and_o   (and_r),
    .or_o    (or_r)
  );

  alu_result_mux #(.WIDTH(WIDTH)) u_mux (
    .func_i (func_i),
    .and_i  (and_r),
    .or_i   (or_r),
    .sum_i  (sum),
    .y_o    (y_o)
  );

  assign zero_o = ~|y_o;

endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
  parameter int unsigned WIDTH = 32
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [2:0]       func_i,
  input logic [WIDTH-1:0] y_o,
  input logic             zero_o
);

  logic [WIDTH-1:0] ref_add;
  logic [WIDTH-1:0] ref_sub;
  assign ref_add = a_i + b_i;
  assign ref_sub = a_i - b_i;

  always_comb begin
    if (func_i == 3'b000) begin
      a_r1_and: assert (y_o == (a_i & b_i)) else $error("R1 and mismatch");
    end
    if (func_i == 3'b001) begin
      a_r2_or: assert (y_o == (a_i | b_i)) else $error("R2 or mismatch");
    end
    if (func_i == 3'b010) begin
      a_r3_add: assert (y_o == ref_add) else $error("R3 add mismatch");
    end
    if (func_i == 3'b100) begin
      a_r4_andn: assert (y_o == (a_i & ~b_i)) else $error("R4 and-not mismatch");
    end
    if (func_i == 3'b101) begin
      a_r4_orn: assert (y_o == (a_i | ~b_i)) else $error("R4 or-not mismatch");
    end
    if (func_i == 3'b110) begin
      a_r5_sub: assert (y_o == ref_sub) else $error("R5 subtract mismatch");
    end
    if (func_i == 3'b111) begin
      a_r6_slt: assert (y_o == {{(WIDTH-1){1'b0}}, ref_sub[WIDTH-1]}) else $error("R6 slt mismatch");
    end
    if (func_i == 3'b011) begin
      a_r7_unused: assert (y_o == '0) else $error("R7 unused code mismatch");
    end
    a_r8_zero: assert (zero_o == (y_o == '0)) else $error("R8 zero flag mismatch");
  end

endmodule

bind alu_core alu_core_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i    (a_i),
  .b_i    (b_i),
  .func_i (func_i),
  .y_o    (y_o),
  .zero_o (zero_o)
);

// File: tb/alu_core_bench.sv
module alu_core_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5ns clk = ~clk;

  logic [31:0] a, b, y;
  logic [2:0]  f;
  logic        z;
  logic [3:0]  na, nb, ny;
  logic [2:0]  nf;
  logic        nz;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  alu_core #(.WIDTH(32)) u_alu_core (
    .a_i(a), .b_i(b), .func_i(f), .y_o(y), .zero_o(z)
  );

  alu_core #(.WIDTH(4)) u_alu_core_narrow (
    .a_i(na), .b_i(nb), .func_i(nf), .y_o(ny), .zero_o(nz)
  );

  // Behavioural model of the requirements for a width of w bits (w <= 32).
  function automatic logic [31:0] model(int unsigned w, logic [31:0] x, logic [31:0] v, logic [2:0] c);
    logic [31:0] m;
    logic [31:0] d;
    m = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    d = (x - v) & m;
    case (c)
      3'b000: return x & v & m;
      3'b001: return (x | v) & m;
      3'b010: return (x + v) & m;
      3'b100: return x & ~v & m;
      3'b101: return (x | ~v) & m;
      3'b110: return d;
      3'b111: return (d >> (w - 1)) & 32'd1;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(logic [2:0] c);
    case (c)
      3'b000: return "R1";
      3'b001: return "R2";
      3'b010: return "R3";
      3'b100: return "R4";
      3'b101: return "R4";
      3'b110: return "R5";
      3'b111: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp, logic gz, logic ez);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: y actual %h expected %h", tag, got, exp);
    end
    checks++;
    if (gz !== ez) begin
      errors++;
      $display("FAIL R8 (%s): zero actual %b expected %b", tag, gz, ez);
    end
  endtask

  task automatic run32(logic [31:0] x, logic [31:0] v, logic [2:0] c, string tag);
    logic [31:0] e;
    @(posedge clk);
    a = x; b = v; f = c;
    @(negedge clk);
    e = model(32, x, v, c);
    check(tag, y, e, z, e == 32'd0);
  endtask

  logic [31:0] edges [9];

  initial begin
    edges[0] = 32'h0000_0000; edges[1] = 32'h0000_0001; edges[2] = 32'd25;
    edges[3] = 32'd32;        edges[4] = 32'h7FFF_FFFF; edges[5] = 32'h8000_0000;
    edges[6] = 32'hFFFF_FFFF; edges[7] = 32'h1234_5678; edges[8] = 32'hA5A5_A5A5;
    a = '0; b = '0; f = '0; na = '0; nb = '0; nf = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Idle inputs: AND of zeros gives zero with the flag set.
    check("R1 idle", y, 32'd0, z, 1'b1);

    // Named corner cases.
    run32(32'd25, 32'd32, 3'b111, "R6 25<32");
    run32(32'h8000_0000, 32'd1, 3'b111, "R6 wrap");
    run32(32'hFFFF_FFFF, 32'd1, 3'b010, "R3 carry drop");
    run32(32'h1234_5678, 32'h1234_5678, 3'b110, "R5 equal");
    run32(32'h1234_5678, 32'h1234_5678, 3'b111, "R6 equal");
    run32(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b011, "R7 ones");
    run32(32'hF0F0_F0F0, 32'h0FF0_0FF0, 3'b100, "R4 andn");
    run32(32'hF0F0_F0F0, 32'h0FF0_0FF0, 3'b101, "R4 orn");
    run32(32'hF0F0_F0F0, 32'h0FF0_0FF0, 3'b000, "R1 and");
    run32(32'hF0F0_F0F0, 32'h0FF0_0FF0, 3'b001, "R2 or");

    // Cross product of edge operands over every code.
    for (int i = 0; i < 9; i++)
      for (int j = 0; j < 9; j++)
        for (int c = 0; c < 8; c++)
          run32(edges[i], edges[j], 3'(c), tag_of(3'(c)));

    // Exhaustive sweep of the 4-bit configuration (R9).
    for (int c = 0; c < 8; c++)
      for (int i = 0; i < 16; i++)
        for (int j = 0; j < 16; j++) begin
          logic [31:0] e;
          @(posedge clk);
          na = 4'(i); nb = 4'(j); nf = 3'(c);
          @(negedge clk);
          e = model(4, 32'(i), 32'(j), 3'(c));
          check({"R9 ", tag_of(3'(c))}, {28'd0, ny}, e, nz, e == 32'd0);
        end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule